// File: doc/BRIEF.md
# Variable Thread-Block Wavefront Sequencer

This block takes one 40-bit instruction at a time from a fetch stage and plays it out across the thread space of a SIMT core as a run of 16-lane wavefronts. On each issue cycle it drives a lane-enable vector, the index of the wavefront in flight, and the per-lane register-file addresses. These addresses are formed by placing the wavefront index above the 4-bit register number. Arithmetic and logic instructions advance one wavefront per cycle. Shared-memory loads move four lanes per cycle. Stores move a single lane per cycle.

A 4-bit shaping field in each instruction can narrow the active width, counted from lane 0, and the active depth, counted from wavefront 0. One instruction can therefore cover every configured thread, a single wavefront, or a single thread. A narrowed instruction runs in fewer cycles. The new shape applies to that instruction only, and no pipeline drain is needed. A snoop flag confines the instruction to wavefront 0 and takes the upper bits of both source addresses from the immediate. This lets a lane read registers that belong to any wavefront. Data hazards are left to software.

Top module: `wavefront_sequencer`

## Requirements
- R1: Instruction fields are decoded as follows. Bits [35:30] form the opcode, [29:28] the numeric type, [27:24] the destination register, [23:20] source A, [19:16] source B, bit 15 the snoop flag, and [14:0] an immediate. The immediate is presented sign-extended to 32 bits on `imm_ext`. Opcode, type and immediate stay stable for every issue cycle of that instruction.
- R2: Bits [39:38] select the active width: 0 gives lanes 0-15, 1 gives lanes 0-7, 2 gives lanes 0-3 and 3 gives lane 0 only.
- R3: Bits [37:36] select the depth. The full depth D is ceil(`thread_count`/16), with 0 treated as 1. Code 0 runs D wavefronts, 1 runs ceil(D/2), 2 runs ceil(D/4) and 3 runs one. Wavefronts issue in ascending order from 0, and `thread_count` is sampled when the instruction is accepted.
- R4: Any opcode other than 6'h10 and 6'h11 is an operation (`issue_class` 0). It issues one wavefront per cycle, with all active-width lanes enabled.
- R5: Opcode 6'h10 is a load (`issue_class` 1). Each wavefront takes ceil(width/4) cycles. Each cycle enables the next group of four lanes in ascending order, masked to the active width.
- R6: Opcode 6'h11 is a store (`issue_class` 2). Each wavefront takes one cycle per active lane, enabling exactly one lane per cycle from lane 0 upward.
- R7: The destination address is {wave_idx, rd}. Without snoop, the source addresses are {wave_idx, ra} and {wave_idx, rb}.
- R8: With the snoop flag set, only wavefront 0 issues. The source A address becomes {imm[9:5], ra} and the source B address becomes {imm[4:0], rb}, while the destination address stays {0, rd}.
- R9: `done` is high on exactly the last issue cycle of an instruction. `instr_ready` is high when idle or on that cycle and low on every other issue cycle. An instruction accepted on a `done` cycle starts issuing on the next cycle, with no gap and with its own shape.
- R10: Issue begins on the cycle after acceptance. After reset, `issue_valid` and `done` are low and `instr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_count | input | 10 | Configured number of threads, 1 to 512 |
| instr_valid | input | 1 | An instruction word is offered |
| instr_word | input | 40 | Instruction word |
| instr_ready | output | 1 | Sequencer accepts the offered word this cycle |
| issue_valid | output | 1 | An issue slot is being driven |
| issue_class | output | 2 | 0 operation, 1 load, 2 store |
| lane_en | output | 16 | Per-lane enable for this slot |
| wave_idx | output | 5 | Wavefront in flight |
| op_code | output | 6 | Opcode of the issuing instruction |
| op_type | output | 2 | Numeric type of the issuing instruction |
| rd_addr | output | 9 | Destination register-file address |
| ra_addr | output | 9 | Source A register-file address |
| rb_addr | output | 9 | Source B register-file address |
| imm_ext | output | 32 | Sign-extended immediate |
| done | output | 1 | Last issue cycle of the current instruction |

## Verification
The embedded properties check the following on every cycle:
- a store slot enables exactly one lane;
- a load slot enables between one and four lanes;
- an operation slot advances the wavefront index by one;
- snooping never leaves wavefront 0;
- `done` only appears inside an issue run;
- `instr_ready` stays low until the final slot;
- an issue run never breaks off before `done`.

The exact lane patterns for each width code, the depth arithmetic from the thread count and each depth code, and the cycle counts per class can only be shown by the directed scenarios. The same applies to the addresses formed from the immediate under snoop and to the gap-free hand-over between consecutive instructions of different shapes.

// File: rtl/wavefront_sequencer.sv
module wavefront_sequencer #(
  parameter int LANES   = 16,
  parameter int WAVES   = 32,
  parameter int REGS    = 16,
  parameter int GRP     = 4,
  parameter logic [5:0] LOAD_OP  = 6'h10,
  parameter logic [5:0] STORE_OP = 6'h11
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [$clog2(LANES*WAVES):0]           thread_count,
  input  logic                                   instr_valid,
  input  logic [39:0]                            instr_word,
  output logic                                   instr_ready,
  output logic                                   issue_valid,
  output logic [1:0]                             issue_class,
  output logic [LANES-1:0]                       lane_en,
  output logic [$clog2(WAVES)-1:0]               wave_idx,
  output logic [5:0]                             op_code,
  output logic [1:0]                             op_type,
  output logic [$clog2(WAVES)+$clog2(REGS)-1:0]  rd_addr,
  output logic [$clog2(WAVES)+$clog2(REGS)-1:0]  ra_addr,
  output logic [$clog2(WAVES)+$clog2(REGS)-1:0]  rb_addr,
  output logic [31:0]                            imm_ext,
  output logic                                   done
);
  localparam int LB = $clog2(LANES);
  localparam int WB = $clog2(WAVES);
  localparam int RB = $clog2(REGS);
  localparam int TW = $clog2(LANES*WAVES) + 1;
  localparam logic [1:0] C_OP = 2'd0, C_LD = 2'd1, C_ST = 2'd2;

  logic          busy;
  logic [39:0]   cur;
  logic [1:0]    cls;
  logic [LANES-1:0] wmask;
  logic [WB-1:0] wv, last_w;
  logic [LB-1:0] sb, last_s;

  // shape of the offered instruction
  logic [3:0]    nvar;
  logic [5:0]    nop;
  logic          nsnoop;
  logic [1:0]    ncls;
  logic [TW-1:0] full_d, ndepth;
  logic [LB:0]   nw;
  logic [LANES:0] one_sh;
  logic [LB-1:0] nsl;

  assign nvar   = instr_word[39:36];
  assign nop    = instr_word[35:30];
  assign nsnoop = instr_word[15];
  assign ncls   = (nop == LOAD_OP) ? C_LD : (nop == STORE_OP) ? C_ST : C_OP;
  assign full_d = TW'((thread_count + TW'(LANES-1)) >> LB);

  always_comb begin
    case (nvar[1:0])
      2'd0:    ndepth = full_d;
      2'd1:    ndepth = (full_d + TW'(1)) >> 1;
      2'd2:    ndepth = (full_d + TW'(3)) >> 2;
      default: ndepth = TW'(1);
    endcase
    if (ndepth == '0) ndepth = TW'(1);
    case (nvar[3:2])
      2'd0:    nw = (LB+1)'(LANES);
      2'd1:    nw = (LB+1)'(LANES/2);
      2'd2:    nw = (LB+1)'(LANES/4);
      default: nw = (LB+1)'(1);
    endcase
    case (ncls)
      C_LD:    nsl = LB'((int'(nw) + GRP - 1) / GRP - 1);
      C_ST:    nsl = LB'(int'(nw) - 1);
      default: nsl = '0;
    endcase
  end

  assign one_sh = (LANES+1)'(1) << nw;

  assign instr_ready = !busy || done;
  assign done        = busy && (wv == last_w) && (sb == last_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur    <= '0;
      cls    <= C_OP;
      wmask  <= '0;
      wv     <= '0;
      sb     <= '0;
      last_w <= '0;
      last_s <= '0;
    end else if (instr_valid && instr_ready) begin
      busy   <= 1'b1;
      cur    <= instr_word;
      cls    <= ncls;
      wmask  <= LANES'(one_sh - (LANES+1)'(1));
      wv     <= '0;
      sb     <= '0;
      last_w <= nsnoop ? '0 : WB'(ndepth - TW'(1));
      last_s <= nsl;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (sb == last_s) begin
        sb <= '0;
        wv <= wv + WB'(1);
      end else begin
        sb <= sb + LB'(1);
      end
    end
  end

  always_comb begin
    lane_en = '0;
    if (busy) begin
      case (cls)
        C_LD:    lane_en = wmask & (LANES'((1 << GRP) - 1) << (int'(sb) * GRP));
        C_ST:    lane_en = wmask & (LANES'(1) << sb);
        default: lane_en = wmask;
      endcase
    end
  end

  assign issue_valid = busy;
  assign issue_class = cls;
  assign wave_idx    = wv;
  assign op_code     = cur[35:30];
  assign op_type     = cur[29:28];
  assign imm_ext     = {{17{cur[14]}}, cur[14:0]};
  assign rd_addr     = {wv, cur[24 +: RB]};
  assign ra_addr     = {cur[15] ? cur[WB +: WB] : wv, cur[20 +: RB]};
  assign rb_addr     = {cur[15] ? cur[0  +: WB] : wv, cur[16 +: RB]};

  a_r6_store_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_class == C_ST) |-> $onehot(lane_en));
  a_r5_load_group: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_class == C_LD) |-> ($countones(lane_en) <= GRP && lane_en != '0));
  a_r4_op_wave_step: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !done && issue_class == C_OP) |=> (wave_idx == $past(wave_idx) + WB'(1)));
  a_r8_snoop_wave0: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && cur[15]) |-> (wave_idx == '0));
  a_r9_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> issue_valid);
  a_r9_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !done) |-> !instr_ready);
  a_r9_no_break: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !done) |=> issue_valid);
endmodule

// File: tb/wavefront_sequencer_test.sv
`timescale 1ns/1ps
module wavefront_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  thread_count = 10'd16;
  logic        instr_valid = 1'b0;
  logic [39:0] instr_word = '0;
  logic        instr_ready, issue_valid, done;
  logic [1:0]  issue_class, op_type;
  logic [15:0] lane_en;
  logic [4:0]  wave_idx;
  logic [5:0]  op_code;
  logic [8:0]  rd_addr, ra_addr, rb_addr;
  logic [31:0] imm_ext;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wavefront_sequencer uut (
    .clk(clk), .rst_n(rst_n), .thread_count(thread_count),
    .instr_valid(instr_valid), .instr_word(instr_word), .instr_ready(instr_ready),
    .issue_valid(issue_valid), .issue_class(issue_class), .lane_en(lane_en),
    .wave_idx(wave_idx), .op_code(op_code), .op_type(op_type),
    .rd_addr(rd_addr), .ra_addr(ra_addr), .rb_addr(rb_addr),
    .imm_ext(imm_ext), .done(done));

  function automatic logic [39:0] mk(input logic [3:0] v, input logic [5:0] op,
      input logic [1:0] ty, input logic [3:0] rd, input logic [3:0] ra,
      input logic [3:0] rb, input logic x, input logic [14:0] imm);
    return {v, op, ty, rd, ra, rb, x, imm};
  endfunction

  task automatic chk(input string what, input logic [92:0] got, input logic [92:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // Called at the negedge where the first slot is visible; returns at the negedge after the last slot.
  task automatic expect_instr(input logic [39:0] w, input int tc, input string tag);
    int wd, fd, dp, cls, spw;
    logic [15:0] m;
    case (w[39:38]) 2'd0: wd = 16; 2'd1: wd = 8; 2'd2: wd = 4; default: wd = 1; endcase
    fd = (tc + 15) / 16;
    if (fd == 0) fd = 1;
    case (w[37:36]) 2'd0: dp = fd; 2'd1: dp = (fd + 1) / 2; 2'd2: dp = (fd + 3) / 4; default: dp = 1; endcase
    if (w[15]) dp = 1;
    cls = (w[35:30] == 6'h10) ? 1 : (w[35:30] == 6'h11) ? 2 : 0;
    spw = (cls == 0) ? 1 : (cls == 1) ? (wd + 3) / 4 : wd;
    m = 16'((32'd1 << wd) - 1);
    for (int wv = 0; wv < dp; wv++) begin
      for (int s = 0; s < spw; s++) begin
        logic [15:0] le;
        logic last;
        logic [8:0] era, erb;
        logic [92:0] g, e;
        le = (cls == 0) ? m : (cls == 1) ? (m & (16'hF << (4 * s))) : (16'd1 << s);
        last = (wv == dp - 1) && (s == spw - 1);
        era = w[15] ? {w[9:5], w[23:20]} : {5'(wv), w[23:20]};
        erb = w[15] ? {w[4:0], w[19:16]} : {5'(wv), w[19:16]};
        e = {1'b1, last, last, 2'(cls), le, 5'(wv), {5'(wv), w[27:24]}, era, erb,
             w[35:30], w[29:28], {{17{w[14]}}, w[14:0]}};
        g = {issue_valid, instr_ready, done, issue_class, lane_en, wave_idx, rd_addr,
             ra_addr, rb_addr, op_code, op_type, imm_ext};
        chk($sformatf("%s wave %0d slot %0d", tag, wv, s), g, e);
        @(negedge clk);
      end
    end
  endtask

  task automatic idle_chk(input string tag);
    chk({tag, " R10 idle after run"}, {90'd0, issue_valid, instr_ready, done}, {90'd0, 3'b010});
  endtask

  task automatic run_single(input logic [39:0] w, input int tc, input string tag);
    @(negedge clk);
    instr_word = w; thread_count = 10'(tc); instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    expect_instr(w, tc, tag);
    idle_chk(tag);
  endtask

  task automatic t_reset;
    chk("R10 reset state", {90'd0, issue_valid, instr_ready, done}, {90'd0, 3'b010});
  endtask
  task automatic t_op_full;   // R4 R3 R2 R7 R1
    run_single(mk(4'b0000, 6'h01, 2'd2, 4'd3, 4'd5, 4'd7, 1'b0, 15'h1234), 512, "R4 R7 op full shape");
  endtask
  task automatic t_op_half;   // R2 R3
    run_single(mk(4'b0101, 6'h02, 2'd0, 4'd1, 4'd2, 4'd3, 1'b0, 15'h7FFF), 100, "R2 R3 op half/half");
  endtask
  task automatic t_op_single; // R2 R3 and negative immediate R1
    run_single(mk(4'b1110, 6'h03, 2'd1, 4'd9, 4'd8, 4'd6, 1'b0, 15'h4001), 100, "R1 R3 op single/quarter");
  endtask
  task automatic t_depth_one; // R3 code 3
    run_single(mk(4'b0011, 6'h04, 2'd0, 4'd2, 4'd2, 4'd2, 1'b0, 15'h0), 512, "R3 depth one");
  endtask
  task automatic t_load_full; // R5
    run_single(mk(4'b0000, 6'h10, 2'd0, 4'd4, 4'd1, 4'd0, 1'b0, 15'h0010), 40, "R5 load full width");
  endtask
  task automatic t_load_half; // R5
    run_single(mk(4'b0100, 6'h10, 2'd2, 4'd4, 4'd1, 4'd0, 1'b0, 15'h0020), 64, "R5 load half width");
  endtask
  task automatic t_store_q;   // R6
    run_single(mk(4'b1011, 6'h11, 2'd0, 4'd6, 4'd2, 4'd0, 1'b0, 15'h0003), 512, "R6 store quarter");
  endtask
  task automatic t_store_full; // R6
    run_single(mk(4'b0010, 6'h11, 2'd0, 4'd6, 4'd2, 4'd0, 1'b0, 15'h0003), 48, "R6 store full width");
  endtask
  task automatic t_snoop;     // R8
    run_single(mk(4'b0000, 6'h05, 2'd2, 4'd7, 4'd3, 4'd4, 1'b1, 15'b00000_10110_01001), 512, "R8 snoop");
  endtask
  task automatic t_tc_zero;   // R3 zero thread count
    run_single(mk(4'b0000, 6'h06, 2'd0, 4'd1, 4'd1, 4'd1, 1'b0, 15'h0), 0, "R3 zero threads");
  endtask
  task automatic t_back2back; // R9
    logic [39:0] a, b;
    a = mk(4'b0000, 6'h07, 2'd2, 4'd1, 4'd2, 4'd3, 1'b0, 15'h0055);
    b = mk(4'b1100, 6'h11, 2'd0, 4'd5, 4'd6, 4'd7, 1'b1, 15'b00000_00011_11100);
    @(negedge clk);
    instr_word = a; thread_count = 10'd64; instr_valid = 1'b1;
    @(negedge clk);
    instr_word = b;
    expect_instr(a, 64, "R9 back-to-back first");
    instr_valid = 1'b0;
    expect_instr(b, 64, "R9 back-to-back second");
    idle_chk("R9 back-to-back");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_op_full();
    t_op_half();
    t_op_single();
    t_depth_one();
    t_load_full();
    t_load_half();
    t_store_q();
    t_store_full();
    t_snoop();
    t_tc_zero();
    t_back2back();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule